// File: doc/BRIEF.md
# Receive Descriptor Chain DMA Engine

This block moves received frames from a byte stream into buffers that software describes with a linked chain of descriptors in a word-addressed memory. Each descriptor occupies four consecutive words at a word address D. D+0 holds the address of the next descriptor, or zero at the end of the chain. D+1 holds the word address of the data buffer. D+2 holds the buffer length in bytes in bits [15:0]. D+3 holds a 16-bit flag field in bits [31:16] and the received data length in bits [15:0]. The flag bits are start-of-frame 0x8000, end-of-frame 0x4000, hardware-owns 0x2000 and end-of-chain 0x1000.

Software hands descriptors to the engine by setting the ownership flag and then writing the first descriptor's address to the head-pointer input. The engine reads the four descriptor words and accepts one frame into that descriptor's buffer. It then writes word D+3 back, which returns ownership, raises the receive interrupt and moves to the next descriptor. A null next pointer stops the engine until software writes the head pointer again. Software clears the interrupt by writing the completed descriptor's address to the acknowledge input.

The memory port is single-ported. A read issued in one cycle returns its data on `mem_rdata` in the following cycle. A write takes effect at the clock edge where it is issued.

Top module: `rxd_chain_dma`

## Requirements
- R1: After reset `rx_ready`, `rx_irq` and `mem_req` are low and `ovr_count` is zero.
- R2: A head-pointer write of a nonzero address P makes the engine read words P, P+1, P+2 and P+3 in that order. `rx_ready` rises in the ninth cycle after the write cycle. The engine issues no memory read while `rx_ready` is high.
- R3: Received bytes are packed little-endian into buffer words, with the first byte of the frame in bits [7:0] of the buffer's first word. In the last word written, the lanes above the final stored byte are written as zero.
- R4: On completion the engine writes descriptor word D+3. The flag field has start-of-frame and end-of-frame set and hardware-owns cleared. The data length goes in bits [15:0].
- R5: At most min(buffer length, `max_len`) bytes are stored. Further bytes of the frame are accepted and discarded, and no buffer word past the stored bytes is written. The data length field holds the stored byte count.
- R6: When the completed descriptor's next pointer is nonzero, its flag field is exactly 0xC000. The engine then fetches the next descriptor and accepts the next frame into it.
- R7: When the completed descriptor's next pointer is zero, its flag field is 0xD000, so end-of-chain is set. The engine then keeps `rx_ready` low until the head pointer is written again.
- R8: If the fetched descriptor's hardware-owns flag is clear, the engine accepts the next frame and discards it without any memory write. It then adds one to `ovr_count` and stops with `rx_ready` low.
- R9: `rx_irq` rises after each descriptor completion. An acknowledge write of the last completed descriptor's address clears it. An acknowledge of any other address leaves it set.
- R10: A head-pointer write of zero stops the engine at once: `rx_ready` drops and no descriptor is written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Head-pointer write strobe |
| ptr_data | input | AW | Descriptor word address to start from (zero stops) |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_data | input | AW | Address of the descriptor software has processed |
| max_len | input | 16 | Largest frame length stored, in bytes |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |
| rx_irq | output | 1 | Receive interrupt, held until acknowledged |
| ovr_count | output | CW | Count of frames dropped for lack of an owned descriptor |

## Verification
Some properties are checked by the assertions on every cycle. Every descriptor write-back must return ownership, set both frame flags, carry a length no larger than `max_len`, and set end-of-chain when the next pointer is null. The interrupt must follow each write-back and must fall on a matching acknowledge. A dropped frame must not touch memory, and the overrun count may only step by one. Other behaviour is shown only by the bench's scenarios: the byte packing and zero-filling, the truncation boundaries, the fetch timing and order, chained traversal, and the stop on a null pointer or a zero head-pointer write.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_W = 32;
  localparam logic [15:0] FL_SOP = 16'h8000;
  localparam logic [15:0] FL_EOP = 16'h4000;
  localparam logic [15:0] FL_OWN = 16'h2000;
  localparam logic [15:0] FL_EOQ = 16'h1000;
  localparam int OWN_BIT = 16 + 13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDCAP,
    ST_RECV,
    ST_WB,
    ST_DROP
  } st_t;

  // smaller of two byte counts
  function automatic logic [15:0] clip_len(input logic [15:0] a, input logic [15:0] b);
    return (a < b) ? a : b;
  endfunction

  // status word written back to descriptor word 3
  function automatic logic [WORD_W-1:0] done_word(input logic chain_end, input logic [15:0] len);
    logic [15:0] f;
    f = FL_SOP | FL_EOP;
    if (chain_end) f = f | FL_EOQ;
    return {f, len};
  endfunction
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          store,
  input  logic          flush,
  input  logic [1:0]    lane,
  input  logic [7:0]    byte_in,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] word_idx,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data
);
  logic [23:0] acc_q;
  logic [31:0] merged;

  always_comb begin
    merged = {8'h00, acc_q};
    merged[lane*8 +: 8] = byte_in;
  end

  assign wr_en   = store && ((lane == 2'd3) || flush);
  assign wr_addr = base + word_idx;
  assign wr_data = merged;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc_q <= '0;
    else if (store) acc_q <= wr_en ? 24'h0 : merged[23:0];
  end
endmodule

// File: rtl/rxd_irq_track.sv
module rxd_irq_track #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [AW-1:0] set_addr,
  input  logic          ack_wr,
  input  logic [AW-1:0] ack_addr,
  output logic          irq,
  output logic [AW-1:0] done_addr
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      done_addr <= '0;
    end else if (set) begin
      pend_q    <= 1'b1;
      done_addr <= set_addr;
    end else if (ack_wr && (ack_addr == done_addr)) begin
      pend_q <= 1'b0;
    end
  end

  assign irq = pend_q;
endmodule

// File: rtl/rxd_chain_dma.sv
module rxd_chain_dma
  import rxd_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_data,
  input  logic          ack_wr,
  input  logic [AW-1:0] ack_data,
  input  logic [15:0]   max_len,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          rx_irq,
  output logic [CW-1:0] ovr_count
);
  localparam logic [15:0] CNT_MAX = 16'hFFFF;

  st_t           st;
  logic [1:0]    idx;
  logic [AW-1:0] cur, nxt, bufa;
  logic [15:0]   blen, cnt;

  logic [15:0]   limit, stored;
  logic          take, store, flush, pk_clr;
  logic          pk_wr;
  logic [AW-1:0] pk_addr;
  logic [31:0]   pk_data;

  // named events for the checker
  logic          wb_evt, nxt_null, dropping;
  logic [AW-1:0] done_addr;
  logic          unused_rd;

  assign unused_rd = ^mem_rdata;
  assign limit     = clip_len(blen, max_len);
  assign stored    = clip_len(cnt, limit);
  assign rx_ready  = (st == ST_RECV) || (st == ST_DROP);
  assign take      = rx_valid && rx_ready;
  assign store     = take && (st == ST_RECV) && (cnt < limit);
  assign flush     = rx_last || ((cnt + 16'd1) == limit);
  assign pk_clr    = (st == ST_RDCAP) && (idx == 2'd3);
  assign wb_evt    = (st == ST_WB);
  assign nxt_null  = (nxt == '0);
  assign dropping  = (st == ST_DROP);

  rxd_packer #(.AW(AW)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pk_clr),
    .store    (store),
    .flush    (flush),
    .lane     (cnt[1:0]),
    .byte_in  (rx_data),
    .base     (bufa),
    .word_idx (AW'(cnt[15:2])),
    .wr_en    (pk_wr),
    .wr_addr  (pk_addr),
    .wr_data  (pk_data)
  );

  rxd_irq_track #(.AW(AW)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (wb_evt),
    .set_addr  (cur),
    .ack_wr    (ack_wr),
    .ack_addr  (ack_data),
    .irq       (rx_irq),
    .done_addr (done_addr)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_RDREQ: begin
        mem_req  = 1'b1;
        mem_addr = cur + {{(AW-2){1'b0}}, idx};
      end
      ST_RECV: begin
        mem_req   = pk_wr;
        mem_we    = pk_wr;
        mem_addr  = pk_addr;
        mem_wdata = pk_data;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur + AW'(3);
        mem_wdata = done_word(nxt_null, stored);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      cur       <= '0;
      nxt       <= '0;
      bufa      <= '0;
      blen      <= '0;
      cnt       <= '0;
      ovr_count <= '0;
    end else if (ptr_wr) begin
      cur <= ptr_data;
      idx <= '0;
      st  <= (ptr_data != '0) ? ST_RDREQ : ST_IDLE;
    end else begin
      case (st)
        ST_RDREQ: st <= ST_RDCAP;
        ST_RDCAP: begin
          case (idx)
            2'd0: nxt  <= mem_rdata[AW-1:0];
            2'd1: bufa <= mem_rdata[AW-1:0];
            2'd2: blen <= mem_rdata[15:0];
            default: ;
          endcase
          if (idx == 2'd3) begin
            cnt <= '0;
            st  <= mem_rdata[OWN_BIT] ? ST_RECV : ST_DROP;
          end else begin
            idx <= idx + 2'd1;
            st  <= ST_RDREQ;
          end
        end
        ST_RECV: begin
          if (take) begin
            if (cnt != CNT_MAX) cnt <= cnt + 16'd1;
            if (rx_last) st <= ST_WB;
          end
        end
        ST_WB: begin
          if (nxt_null) begin
            cur <= '0;
            st  <= ST_IDLE;
          end else begin
            cur <= nxt;
            idx <= '0;
            st  <= ST_RDREQ;
          end
        end
        ST_DROP: begin
          if (take && rx_last) begin
            ovr_count <= ovr_count + 1'b1;
            cur       <= '0;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxd_chain_dma_chk.sv
module rxd_chain_dma_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [31:0]   mem_wdata,
  input logic          rx_irq,
  input logic [CW-1:0] ovr_count,
  input logic          ack_wr,
  input logic [AW-1:0] ack_data,
  input logic [15:0]   max_len,
  input logic          wb_evt,
  input logic          nxt_null,
  input logic          dropping,
  input logic [AW-1:0] done_addr
);
  a_r2_no_read_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !(mem_req && !mem_we));

  a_r4_wb_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wb_evt |-> (mem_req && mem_we && mem_wdata[31:30] == 2'b11 && !mem_wdata[29]));

  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wb_evt |-> (mem_wdata[15:0] <= max_len));

  a_r7_eoq_on_null: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_evt && nxt_null) |-> mem_wdata[28]);

  a_r6_no_eoq_mid_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_evt && !nxt_null) |-> !mem_wdata[28]);

  a_r8_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    dropping |-> !(mem_req && mem_we));

  a_r8_ovr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_count != $past(ovr_count)) |-> (ovr_count == CW'($past(ovr_count) + 1'b1)));

  a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    wb_evt |=> rx_irq);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && ack_data == done_addr && !wb_evt) |=> !rx_irq);
endmodule

bind rxd_chain_dma rxd_chain_dma_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_ready  (rx_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .rx_irq    (rx_irq),
  .ovr_count (ovr_count),
  .ack_wr    (ack_wr),
  .ack_data  (ack_data),
  .max_len   (max_len),
  .wb_evt    (wb_evt),
  .nxt_null  (nxt_null),
  .dropping  (dropping),
  .done_addr (done_addr)
);

// File: tb/rxd_chain_dma_tb.sv
`timescale 1ns/1ps
module rxd_chain_dma_tb;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ptr_wr = 1'b0;
  logic [AW-1:0] ptr_data = '0;
  logic          ack_wr = 1'b0;
  logic [AW-1:0] ack_data = '0;
  logic [15:0]   max_len = 16'd1522;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_last = 1'b0;
  logic          rx_ready, mem_req, mem_we, rx_irq;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic [CW-1:0] ovr_count;

  always #2 clk = ~clk;

  rxd_chain_dma #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_data(ptr_data),
    .ack_wr(ack_wr), .ack_data(ack_data), .max_len(max_len),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rx_irq(rx_irq), .ovr_count(ovr_count)
  );

  // bench memory, one process owns it
  logic [31:0] mem [1024];
  logic        tb_we = 1'b0;
  logic [9:0]  tb_addr = '0;
  logic [31:0] tb_data = '0;
  int          wr_cnt = 0;
  int          rd_n = 0;
  logic [AW-1:0] rd_log [4];

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_req && mem_we) wr_cnt <= wr_cnt + 1;
    if (mem_req && !mem_we && rd_n < 4) begin
      rd_log[rd_n] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  task automatic poke(input int a, input logic [31:0] d);
    tb_we = 1'b1; tb_addr = a[9:0]; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_desc(input int d, input int nx, input int buf_a, input int blen, input logic own);
    poke(d, nx);
    poke(d + 1, buf_a);
    poke(d + 2, blen);
    poke(d + 3, own ? 32'h2000_0000 : 32'h0);
  endtask

  task automatic fill_buf(input int b, input int n);
    for (int i = 0; i < n; i++) poke(b + i, 32'hFFFF_FFFF);
  endtask

  task automatic write_ptr(input int a);
    ptr_data = a[AW-1:0]; ptr_wr = 1'b1;
    @(negedge clk);
    ptr_wr = 1'b0;
  endtask

  task automatic ack(input int a);
    ack_data = a[AW-1:0]; ack_wr = 1'b1;
    @(negedge clk);
    ack_wr = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = seed + 8'(i); rx_last = (i == n - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic wait_irq();
    for (int t = 0; t < 200 && !rx_irq; t++) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int t = 0; t < 200 && !rx_ready; t++) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] seed, input int nb, input int j);
    logic [31:0] w;
    if (4 * j >= nb) return 32'hFFFF_FFFF;
    w = '0;
    for (int l = 0; l < 4; l++)
      if (4 * j + l < nb) w[l*8 +: 8] = seed + 8'(4 * j + l);
    return w;
  endfunction

  function automatic int min3(input int a, input int b, input int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  // {frame length, buffer length, max_len}
  localparam logic [47:0] VEC [8] = '{
    {16'd5,  16'd64, 16'd1522},
    {16'd8,  16'd64, 16'd1522},
    {16'd1,  16'd64, 16'd1522},
    {16'd20, 16'd10, 16'd1522},
    {16'd20, 16'd64, 16'd7},
    {16'd3,  16'd0,  16'd1522},
    {16'd12, 16'd12, 16'd12},
    {16'd40, 16'd64, 16'd1522}
  };

  initial begin
    int cyc;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'd0);
    chk("R1 rx_irq", {31'b0, rx_irq}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 ovr_count", 32'(ovr_count), 32'd0);

    // table walk: R3 R4 R5 R7 R9
    for (int k = 0; k < 8; k++) begin
      int flen, blen, ml, nb;
      logic [7:0] seed;
      flen = int'(VEC[k][47:32]);
      blen = int'(VEC[k][31:16]);
      ml   = int'(VEC[k][15:0]);
      seed = 8'(8'h10 * k + 1);
      nb   = min3(flen, blen, ml);
      max_len = ml[15:0];
      set_desc(32'h10, 0, 32'h100, blen, 1'b1);
      fill_buf(32'h100, 14);
      write_ptr(32'h10);
      send_frame(flen, seed);
      wait_irq();
      chk("R9 irq after completion", {31'b0, rx_irq}, 32'd1);
      chk("R4 R5 R7 status word", mem[32'h13], {16'hD000, 16'(nb)});
      for (int j = 0; j < 14; j++)
        chk("R3 R5 buffer word", mem[32'h100 + j], exp_word(seed, nb, j));
      repeat (3) @(negedge clk);
      chk("R7 stopped after null next", {31'b0, rx_ready}, 32'd0);
      ack(32'h10);
      chk("R9 ack clears", {31'b0, rx_irq}, 32'd0);
    end
    max_len = 16'd1522;

    // R2 R6 chain of two descriptors
    set_desc(32'h40, 32'h50, 32'h200, 64, 1'b1);
    set_desc(32'h50, 0, 32'h240, 64, 1'b1);
    fill_buf(32'h240, 4);
    rd_n = 0;
    @(negedge clk);
    write_ptr(32'h40);
    cyc = 1;
    while (!rx_ready && cyc < 50) begin @(negedge clk); cyc++; end
    chk("R2 fetch latency", cyc, 9);
    for (int i = 0; i < 4; i++) chk("R2 fetch order", 32'(rd_log[i]), 32'h40 + i);
    send_frame(6, 8'hA0);
    wait_irq();
    chk("R6 mid-chain status", mem[32'h43], {16'hC000, 16'd6});
    ack(32'h50);
    chk("R9 foreign ack ignored", {31'b0, rx_irq}, 32'd1);
    ack(32'h40);
    chk("R9 matching ack clears", {31'b0, rx_irq}, 32'd0);
    send_frame(9, 8'hB0);
    wait_irq();
    chk("R6 R7 second status", mem[32'h53], {16'hD000, 16'd9});
    chk("R6 R3 second buffer word0", mem[32'h240], 32'hB3B2B1B0);
    chk("R6 R3 second buffer word2", mem[32'h242], 32'h000000B8);
    ack(32'h50);

    // R8 descriptor not owned
    set_desc(32'h60, 0, 32'h280, 64, 1'b0);
    fill_buf(32'h280, 2);
    write_ptr(32'h60);
    wait_ready();
    cyc = wr_cnt;
    send_frame(5, 8'h33);
    @(negedge clk);
    chk("R8 no writes on drop", wr_cnt, cyc);
    chk("R8 overrun counted", 32'(ovr_count), 32'd1);
    chk("R8 stopped", {31'b0, rx_ready}, 32'd0);
    chk("R8 descriptor untouched", mem[32'h63], 32'h0);
    chk("R8 buffer untouched", mem[32'h280], 32'hFFFF_FFFF);
    chk("R8 no irq", {31'b0, rx_irq}, 32'd0);

    // R10 zero head pointer idles
    set_desc(32'h70, 0, 32'h2C0, 64, 1'b1);
    write_ptr(32'h70);
    wait_ready();
    chk("R10 ready before stop", {31'b0, rx_ready}, 32'd1);
    write_ptr(0);
    chk("R10 ready dropped", {31'b0, rx_ready}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R10 no write-back", mem[32'h73], 32'h2000_0000);
    chk("R10 no irq", {31'b0, rx_irq}, 32'd0);
    chk("R10 idle memory", {31'b0, mem_req}, 32'd0);

    report();
  end
endmodule